// File: doc/BRIEF.md
# Pet Feeder Button Sequencer

This block is the decision core of an automatic pet feeder. Two push buttons, red and blue, are sampled only on cycles where a slow enable pulse (`tick`, nominally one per second) is high. Three red presses in a row switch on the food dispenser request; two blue presses in a row switch on the water dispenser request. A press of the other colour partway through a sequence abandons it. Once a dispenser request is on, the next press of either button switches it off and returns the machine to its resting state.

The machine is a Moore state machine with six named states. ST_IDLE is the resting state. ST_RED1 and ST_RED2 count one and two red presses. ST_FOOD drives the food request. ST_BLUE1 counts one blue press. ST_WATER drives the water request. A press is any ticked cycle with a button high. The transitions are:
- ST_IDLE to ST_RED1 (red) or ST_BLUE1 (blue).
- ST_RED1 to ST_RED2 (red).
- ST_RED2 to ST_FOOD (red).
- ST_BLUE1 to ST_WATER (blue).
- Any counting state to ST_IDLE (other colour).
- ST_FOOD or ST_WATER to ST_IDLE (any press).
- Any state to ST_IDLE (both buttons on one tick).
- Every state to itself when there is no press.

Top module: `pet_feeder_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the machine in ST_IDLE on the next clock edge, with `food_en` and `water_en` both 0.
- R2: On a cycle with `tick` low the state does not change, whatever the buttons show.
- R3: A cycle with `tick` high and both buttons low leaves the state unchanged.
- R4: Three consecutive ticked red presses from ST_IDLE set `food_en` to 1 after the clock edge of the third press. `food_en` is 1 only in ST_FOOD.
- R5: Two consecutive ticked blue presses from ST_IDLE set `water_en` to 1 after the clock edge of the second press. `water_en` is 1 only in ST_WATER.
- R6: A press of the other colour in ST_RED1, ST_RED2 or ST_BLUE1 returns the machine to ST_IDLE. That press does not count toward a new sequence.
- R7: In ST_FOOD or ST_WATER, any ticked press returns the machine to ST_IDLE and clears both outputs.
- R8: A ticked cycle with both buttons high returns the machine to ST_IDLE from any state.
- R9: `food_en` and `water_en` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sampling enable; buttons are taken into account only when it is high |
| red_btn | input | 1 | Red button, 1 = pressed |
| blue_btn | input | 1 | Blue button, 1 = pressed |
| food_en | output | 1 | Food dispenser request (Moore output of ST_FOOD) |
| water_en | output | 1 | Water dispenser request (Moore output of ST_WATER) |

## Verification
The block has no parameters, so the bench builds the one fixed configuration. In that configuration all six states and every transition between them can be reached in a few dozen ticks. That makes it possible to walk each arc on purpose: the aborts from each counting state, the cancels from both output states, the two-button case and long stretches without a tick in the middle of a sequence. The reference model counts presses with plain integers and is compared with both outputs on every clock.

// File: rtl/feeder_pkg.sv
package feeder_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RED1  = 3'd1,
        ST_RED2  = 3'd2,
        ST_FOOD  = 3'd3,
        ST_BLUE1 = 3'd4,
        ST_WATER = 3'd5
    } feeder_state_t;

    typedef enum logic [1:0] {
        PR_NONE = 2'd0,
        PR_RED  = 2'd1,
        PR_BLUE = 2'd2,
        PR_BOTH = 2'd3
    } press_t;

endpackage

// File: rtl/feeder_press_classify.sv
module feeder_press_classify
    import feeder_pkg::*;
(
    input  logic   tick,
    input  logic   red_btn,
    input  logic   blue_btn,
    output press_t press
);

    // A press exists only on an enabled sample.
    always_comb begin
        press = PR_NONE;
        if (tick) begin
            unique case ({red_btn, blue_btn})
                2'b10:   press = PR_RED;
                2'b01:   press = PR_BLUE;
                2'b11:   press = PR_BOTH;
                default: press = PR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/feeder_seq_fsm.sv
module feeder_seq_fsm
    import feeder_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  press_t        press,
    output feeder_state_t cur_state
);

    feeder_state_t nxt_state;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) cur_state <= ST_IDLE;
        else     cur_state <= nxt_state;
    end

    // Transition logic.
    always_comb begin
        nxt_state = cur_state;
        if (press == PR_BOTH) begin
            nxt_state = ST_IDLE;
        end else if (press != PR_NONE) begin
            unique case (cur_state)
                ST_IDLE:  nxt_state = (press == PR_RED) ? ST_RED1 : ST_BLUE1;
                ST_RED1:  nxt_state = (press == PR_RED) ? ST_RED2 : ST_IDLE;
                ST_RED2:  nxt_state = (press == PR_RED) ? ST_FOOD : ST_IDLE;
                ST_BLUE1: nxt_state = (press == PR_BLUE) ? ST_WATER : ST_IDLE;
                ST_FOOD:  nxt_state = ST_IDLE;
                ST_WATER: nxt_state = ST_IDLE;
                default:  nxt_state = ST_IDLE;
            endcase
        end
    end

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (press == PR_NONE) |=> (cur_state == $past(cur_state)));

    assert_food_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_RED2 && press == PR_RED) |=> (cur_state == ST_FOOD));

    assert_water_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_BLUE1 && press == PR_BLUE) |=> (cur_state == ST_WATER));

    assert_abort_red_R6: assert property (@(posedge clk) disable iff (rst)
        ((cur_state == ST_RED1 || cur_state == ST_RED2) && press == PR_BLUE)
        |=> (cur_state == ST_IDLE));

    assert_abort_blue_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_BLUE1 && press == PR_RED) |=> (cur_state == ST_IDLE));

    assert_cancel_out_R7: assert property (@(posedge clk) disable iff (rst)
        ((cur_state == ST_FOOD || cur_state == ST_WATER) && press != PR_NONE)
        |=> (cur_state == ST_IDLE));

    assert_both_pressed_R8: assert property (@(posedge clk) disable iff (rst)
        (press == PR_BOTH) |=> (cur_state == ST_IDLE));

endmodule

// File: rtl/feeder_out_decode.sv
module feeder_out_decode
    import feeder_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  feeder_state_t cur_state,
    output logic          food_en,
    output logic          water_en
);

    // Moore outputs.
    always_comb begin
        food_en  = 1'b0;
        water_en = 1'b0;
        unique case (cur_state)
            ST_FOOD:  food_en  = 1'b1;
            ST_WATER: water_en = 1'b1;
            default: ;
        endcase
    end

    assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(food_en) && $stable(water_en)));

    assert_outputs_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({food_en, water_en}));

endmodule

// File: rtl/pet_feeder_ctrl.sv
module pet_feeder_ctrl
    import feeder_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic red_btn,
    input  logic blue_btn,
    output logic food_en,
    output logic water_en
);

    press_t        press;
    feeder_state_t cur_state;

    feeder_press_classify u_classify (
        .tick     (tick),
        .red_btn  (red_btn),
        .blue_btn (blue_btn),
        .press    (press)
    );

    feeder_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .press     (press),
        .cur_state (cur_state)
    );

    feeder_out_decode u_out (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cur_state (cur_state),
        .food_en   (food_en),
        .water_en  (water_en)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!food_en && !water_en));

endmodule

// File: tb/pet_feeder_ctrl_tb_top.sv
module pet_feeder_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic red_btn = 1'b0;
    logic blue_btn = 1'b0;
    logic food_en;
    logic water_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string req = "R1";

    // Reference model: press counters and output flags.
    int m_red = 0;
    int m_blue = 0;
    int m_food = 0;
    int m_water = 0;

    always #4 clk = ~clk;

    pet_feeder_ctrl dut_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .red_btn  (red_btn),
        .blue_btn (blue_btn),
        .food_en  (food_en),
        .water_en (water_en)
    );

    task automatic clear_model();
        m_red = 0; m_blue = 0; m_food = 0; m_water = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            clear_model();
        end else if (tick && (red_btn || blue_btn)) begin
            if (m_food != 0 || m_water != 0 || (red_btn && blue_btn)) begin
                clear_model();
            end else if (red_btn) begin
                if (m_blue != 0) clear_model();
                else begin
                    m_red = m_red + 1;
                    if (m_red == 3) begin m_red = 0; m_food = 1; end
                end
            end else begin
                if (m_red != 0) clear_model();
                else begin
                    m_blue = m_blue + 1;
                    if (m_blue == 2) begin m_blue = 0; m_water = 1; end
                end
            end
        end
    end

    task automatic compare();
        total++;
        if (food_en !== m_food[0] || water_en !== m_water[0]) begin
            bad++;
            $display("FAIL %s: food_en=%b water_en=%b expected food_en=%0d water_en=%0d at %0t",
                     req, food_en, water_en, m_food, m_water, $time);
        end
    endtask

    // Drive one cycle after a falling edge; compare at the next falling edge.
    task automatic cyc(input logic t, input logic r, input logic b);
        tick = t; red_btn = r; blue_btn = b;
        @(negedge clk);
        compare();
    endtask

    task automatic press_red();  cyc(1'b1, 1'b1, 1'b0); endtask
    task automatic press_blue(); cyc(1'b1, 1'b0, 1'b1); endtask
    task automatic idle_tick();  cyc(1'b1, 1'b0, 1'b0); endtask

    initial begin
        @(negedge clk);
        req = "R1"; cyc(1'b0, 1'b0, 1'b0); cyc(1'b1, 1'b1, 1'b0);
        rst = 1'b0;
        req = "R1"; cyc(1'b0, 1'b0, 1'b0);

        req = "R4"; press_red(); press_red(); press_red();
        req = "R7"; idle_tick(); press_red();
        req = "R5"; press_blue(); press_blue();
        req = "R7"; press_red();
        req = "R7"; press_red(); press_red(); press_red(); press_blue();
        req = "R5"; press_blue(); press_blue(); req = "R7"; press_blue();

        req = "R6"; press_red(); press_red(); press_blue(); press_red(); press_red(); press_red();
        req = "R7"; press_red();
        req = "R6"; press_blue(); press_red(); press_blue(); press_blue();
        req = "R7"; press_blue();
        req = "R6"; press_red(); press_blue(); press_blue(); press_blue();
        req = "R7"; press_red();

        req = "R2";
        press_red();
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 1'b1);
        press_red(); press_red();
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1);
        press_blue();

        req = "R3";
        press_blue();
        for (int i = 0; i < 5; i++) idle_tick();
        press_blue();
        for (int i = 0; i < 3; i++) idle_tick();
        press_red();

        req = "R8";
        press_red(); press_red(); cyc(1'b1, 1'b1, 1'b1); press_red();
        cyc(1'b1, 1'b1, 1'b1); press_blue(); cyc(1'b1, 1'b1, 1'b1);
        press_red(); press_red(); press_red(); cyc(1'b1, 1'b1, 1'b1);
        press_blue(); press_blue(); cyc(1'b1, 1'b1, 1'b1); cyc(1'b1, 1'b1, 1'b1);

        req = "R1";
        press_red(); press_red(); press_red();
        rst = 1'b1; cyc(1'b1, 1'b1, 1'b0); rst = 1'b0;
        press_red(); press_red(); press_red();

        req = "R9";
        for (int i = 0; i < 40; i++) begin
            case ((i * 7 + i / 3) % 5)
                0: press_red();
                1: press_blue();
                2: idle_tick();
                3: cyc(1'b0, 1'b1, 1'b0);
                default: press_red();
            endcase
            total++;
            if (food_en && water_en) begin
                bad++;
                $display("FAIL R9: food_en=%b water_en=%b expected not both 1", food_en, water_en);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: done=0 expected done=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule